// File: doc/BRIEF.md
# Dual-Rate Serial Baud Generator

This block derives two rate enables, one for a serial transmitter and one for a serial receiver, from a single bus clock. A shared first-stage prescaler divides the clock by one of four factors: 1, 3, 4 or 13. Each side then has its own power-of-two divider, from 1 to 128. The division is set through a single 8-bit configuration register on a small bus port, with a write strobe, write data and read data.

The outputs are enables that are one bus clock wide, not derived clocks. The shift logic of a serial port gates its bit-time state with them. Writing the register restarts all counting. The first enable under a new setting therefore comes exactly one full period after the write.

Top module: `baud_pair_gen`

## Requirements
- R1: The configuration register is 8 bits. Bits 7:6 select the prescaler, bits 5:3 select the transmit divisor and bits 2:0 select the receive divisor. A write stores `wr_data_i` at the clock edge where `wr_en_i` is high. From the next cycle, `rd_data_o` returns the stored value.
- R2: After reset the register holds 0x00. Both tick outputs are high on every cycle until the first write.
- R3: The prescaler select gives these factors: 00 divides by 1, 01 by 3, 10 by 4 and 11 by 13.
- R4: The transmit tick repeats every P × 2^T bus cycles. P is the prescaler factor and T is the transmit select value (0 to 7).
- R5: The receive tick repeats every P × 2^R bus cycles, where R is the receive select value. It is independent of the transmit select.
- R6: Each tick is high for exactly one bus cycle per period. With a total division of 1, the tick is high on every cycle.
- R7: A write clears the prescaler and both divider counts. Count the cycles after the write edge from 1. A tick first rises in cycle P × D, where D is that side's divisor. A write to the same value also restarts the counts.
- R8: The dividers advance only on prescaler ticks. While the prescaler tick is low, a divider's count does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| tx_tick_o | output | 1 | Transmit rate enable, one cycle wide |
| rx_tick_o | output | 1 | Receive rate enable, one cycle wide |

## Verification
The bench sweeps all 32 pairings of prescaler and transmit select. It sets the receive select to the mirrored value, so the two sides always run at different spans. This separates a swapped or shared divider from a correct one, and it covers both the period of 1 cycle and the period of 1664 cycles. Pairings with a divisor of 1 isolate the prescaler factor. The gaps measured right after each write separate a true restart from a divider that only reloads at its next wrap. A same-value rewrite in mid-period and two back-to-back writes probe the restart rule where its timing is most easily got wrong.

// File: rtl/baud_pair_pkg.sv
`timescale 1ns/1ps
package baud_pair_pkg;
  localparam int unsigned CFG_W     = 8;
  localparam int unsigned PRE_SEL_W = 2;
  localparam int unsigned DIV_SEL_W = 3;
  localparam int unsigned PRE_CNT_W = 4;
  localparam int unsigned DIV_CNT_W = (1 << DIV_SEL_W) - 1;
  localparam int unsigned N_SIDES   = 2;

  typedef struct packed {
    logic [PRE_SEL_W-1:0] pre_sel;
    logic [DIV_SEL_W-1:0] tx_sel;
    logic [DIV_SEL_W-1:0] rx_sel;
  } rate_cfg_t;

  // Last count value of the prescaler for each select code (factor - 1).
  function automatic logic [PRE_CNT_W-1:0] pre_last(input logic [PRE_SEL_W-1:0] sel);
    logic [PRE_CNT_W-1:0] v;
    case (sel)
      2'b00:   v = 4'd0;
      2'b01:   v = 4'd2;
      2'b10:   v = 4'd3;
      default: v = 4'd12;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/rate_cfg_reg.sv
`timescale 1ns/1ps
module rate_cfg_reg
  import baud_pair_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output rate_cfg_t        cfg_o,
  output logic [CFG_W-1:0] rd_data_o
);
  rate_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en_i) cfg_d = rate_cfg_t'(wr_data_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o     = cfg_q;
  assign rd_data_o = cfg_q;

  // R1: a write is visible on the read port in the following cycle
  p_readback_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o == $past(wr_data_i)));
  // R1: without a write the stored value holds
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/rate_prescaler.sv
`timescale 1ns/1ps
module rate_prescaler
  import baud_pair_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic [PRE_SEL_W-1:0] sel_i,
  output logic                 tick_o
);
  logic [PRE_CNT_W-1:0] cnt_q, cnt_d;
  logic [PRE_CNT_W-1:0] last;

  assign last   = pre_last(sel_i);
  assign tick_o = (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R3: the count never passes the last value of the selected factor
  p_pre_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
  // R7: a reconfiguration restarts the prescaler from zero
  p_pre_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/rate_divider.sv
`timescale 1ns/1ps
module rate_divider
  import baud_pair_pkg::*;
#(
  parameter int unsigned SEL_W = DIV_SEL_W,
  localparam int unsigned CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam logic [CNT_W-1:0] ONES = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last;

  assign last   = ONES >> (CNT_W - int'(sel_i));
  assign tick_o = adv_i && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (adv_i) cnt_d = (cnt_q == last) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R8: the count only moves on a prescaler tick
  p_div_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(cnt_q));
  // R4 R5: the count stays inside the selected span
  p_div_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last);
endmodule

// File: rtl/baud_pair_gen.sv
`timescale 1ns/1ps
module baud_pair_gen
  import baud_pair_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output logic [CFG_W-1:0] rd_data_o,
  output logic             tx_tick_o,
  output logic             rx_tick_o
);
  rate_cfg_t            cfg;
  logic                 pre_tick;
  logic [DIV_SEL_W-1:0] div_sel  [N_SIDES];
  logic                 div_tick [N_SIDES];

  rate_cfg_reg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .rd_data_o (rd_data_o)
  );

  rate_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr_en_i),
    .sel_i  (cfg.pre_sel),
    .tick_o (pre_tick)
  );

  assign div_sel[0] = cfg.tx_sel;
  assign div_sel[1] = cfg.rx_sel;

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    rate_divider #(.SEL_W(DIV_SEL_W)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (wr_en_i),
      .adv_i  (pre_tick),
      .sel_i  (div_sel[s]),
      .tick_o (div_tick[s])
    );
  end

  assign tx_tick_o = div_tick[0];
  assign rx_tick_o = div_tick[1];

  // R7: with a prescaler above 1, no tick in the cycle right after a write
  p_restart_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_data_i[7:6] != 2'b00)) |=> (!tx_tick_o && !rx_tick_o));
  // R6: an all-zero setting gives a tick on every cycle
  p_unit_rate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o == '0) |-> (tx_tick_o && rx_tick_o));
  // R8: a side tick never appears without a prescaler tick
  p_tick_on_pre_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_tick_o || rx_tick_o) |-> pre_tick);
endmodule

// File: tb/baud_pair_gen_bench.sv
`timescale 1ns/1ps
module baud_pair_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tx_tick, rx_tick;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  baud_pair_gen u_baud_pair_gen (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .tx_tick_o (tx_tick),
    .rx_tick_o (rx_tick)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pre_factor(input logic [1:0] s);
    int f[4] = '{1, 3, 4, 13};
    return f[s];
  endfunction

  // Reference model: cycles since the last write, and the setting in force
  logic [7:0] m_cfg = 8'h00;
  int m_n = 0;
  int gap_tx = 0, gap_rx = 0;
  bit first_tx = 1'b1, first_rx = 1'b1;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int p, ptx, prx;
      bit exp_tx, exp_rx;
      p   = pre_factor(m_cfg[7:6]);
      ptx = p * (1 << m_cfg[5:3]);
      prx = p * (1 << m_cfg[2:0]);
      exp_tx = ((m_n + 1) % ptx) == 0;
      exp_rx = ((m_n + 1) % prx) == 0;
      check(tx_tick == exp_tx, "R4 R6 tx tick", int'(tx_tick), int'(exp_tx));
      check(rx_tick == exp_rx, "R5 R6 rx tick", int'(rx_tick), int'(exp_rx));
      check(rd_data == m_cfg, "R1 readback", int'(rd_data), int'(m_cfg));
      gap_tx++;
      gap_rx++;
      if (tx_tick) begin
        if (first_tx)               check(gap_tx == ptx, "R7 first tx gap", gap_tx, ptx);
        else if (m_cfg[5:3] == 3'd0) check(gap_tx == ptx, "R3 R8 tx gap", gap_tx, ptx);
        else                        check(gap_tx == ptx, "R4 tx gap", gap_tx, ptx);
        gap_tx = 0;
        first_tx = 1'b0;
      end
      if (rx_tick) begin
        if (first_rx) check(gap_rx == prx, "R7 first rx gap", gap_rx, prx);
        else          check(gap_rx == prx, "R5 rx gap", gap_rx, prx);
        gap_rx = 0;
        first_rx = 1'b0;
      end
      if (wr_en) begin
        m_cfg = wr_data;
        m_n = 0;
        gap_tx = 0;
        gap_rx = 0;
        first_tx = 1'b1;
        first_rx = 1'b1;
      end else begin
        m_n++;
      end
    end
  end

  task automatic write_cfg(input logic [7:0] v);
    @(posedge clk); #1;
    wr_en = 1'b1;
    wr_data = v;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic run(input int cycles);
    repeat (cycles) @(posedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    check(rd_data == 8'h00, "R2 reset value", int'(rd_data), 0);
    check(tx_tick && rx_tick, "R2 unit rate after reset", int'({tx_tick, rx_tick}), 3);
    run(20);

    // R3 R4 R5: every prescaler and transmit select, receive mirrored
    for (int p = 0; p < 4; p++) begin
      for (int t = 0; t < 8; t++) begin
        int span;
        span = pre_factor(2'(p)) * 128;
        write_cfg({2'(p), 3'(t), 3'(7 - t)});
        run(2 * span + 3);
      end
    end

    // R7: same-value rewrite in mid-period restarts the count
    write_cfg(8'hFF);
    run(500);
    write_cfg(8'hFF);
    run(3400);

    // R7: back-to-back writes, the later one wins
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = 8'b01_010_001;
    @(posedge clk); #1;
    wr_data = 8'b10_001_011;
    @(posedge clk); #1;
    wr_en = 1'b0;
    run(200);

    // R6: return to unit rate
    write_cfg(8'h00);
    run(10);
    @(negedge clk);
    check(tx_tick && rx_tick, "R6 unit rate", int'({tx_tick, rx_tick}), 3);
    finish_run();
  end
endmodule